// File: doc/BRIEF.md
# Word-to-Byte Bus Data Multiplexer

This block joins a processor that moves 16-bit words to a peripheral bus that moves only bytes. Each processor access, read or write, becomes exactly two byte cycles on the peripheral side. The odd byte address always goes first, and the even byte address follows. On a read, the byte from the odd cycle is held in a latch. When the even byte arrives, both bytes are presented to the processor together as one word. A read always fetches both bytes, even when the processor only needs one of them.

The peripheral can stretch either byte cycle by holding its ready input low. The two phases are independent: the even cycle never starts before the odd cycle has been accepted. After the even cycle, a single-clock done pulse tells the processor that the word is complete. A request that arrives while an access is in progress is not queued. It is ignored until the block is idle again.

Top module: `word_byte_mux`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `per_stb_o` and `cpu_done_o` are low and `cpu_rdata_o` reads zero, even if an access was in flight or a word had been read earlier.
- R2: A request seen at a clock edge while idle starts the odd byte cycle in the next cycle: `per_stb_o` high and `per_addr_o` = {word address, 1}.
- R3: While `per_ready_i` is low during the odd cycle, the strobe stays high and the odd byte address stays unchanged.
- R4: The cycle after the odd cycle completes (strobe high with ready high) is the even byte cycle, with `per_addr_o` = {same word address, 0}. The strobe does not drop between the two cycles.
- R5: While `per_ready_i` is low during the even cycle, the strobe stays high and the even byte address stays unchanged.
- R6: On a read, when `cpu_done_o` is high, `cpu_rdata_o[15:8]` holds the byte returned by the even address and `cpu_rdata_o[7:0]` holds the latched byte returned by the odd address. The value is held until the next read completes.
- R7: `cpu_done_o` goes high in the cycle after the even cycle completes and stays high for exactly one clock.
- R8: On a write, `per_we_o` is high in both byte cycles. The odd cycle drives `cpu_wdata_i[7:0]` on `per_wdata_o`, and the even cycle drives `cpu_wdata_i[15:8]`, both as captured when the request was accepted.
- R9: Request, address, direction and write data presented while an access is in progress have no effect. The running access keeps its original address and data. There is no strobe in the done cycle, and a request withdrawn at the done cycle starts nothing.
- R10: Every access, including a read that needs only one byte, completes exactly two byte cycles before `cpu_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Access request, sampled when idle |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 15 | Word address |
| cpu_wdata_i | input | 16 | Write word; [15:8] goes to the even byte, [7:0] to the odd byte |
| cpu_rdata_o | output | 16 | Read word; [15:8] is the even byte, [7:0] is the odd byte |
| cpu_done_o | output | 1 | One-clock completion pulse |
| per_addr_o | output | 16 | Byte address; bit 0 selects odd (1) or even (0) |
| per_stb_o | output | 1 | Byte cycle active |
| per_we_o | output | 1 | Byte cycle is a write |
| per_wdata_o | output | 8 | Write byte |
| per_rdata_i | input | 8 | Read byte from the peripheral |
| per_ready_i | input | 1 | Peripheral ready; low stretches the current byte cycle |

## Verification
The hardest situation to reach from the ports is a request, with a different address, direction and data, held high across a long stretched access and then withdrawn right at the done pulse. This is the only way to show that busy-time inputs neither retarget the running cycles nor start a second access. The bench gets there with a directed access that inverts every request input while the stretched cycles run, and with random accesses whose per-phase stall counts come from a seeded generator. A reset applied in the middle of a stalled even cycle, after an earlier read has left a nonzero word, shows that the strobe is dropped and the read word is cleared.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ODD  = 2'd1,
    ST_EVEN = 2'd2,
    ST_DONE = 2'd3
  } wbm_state_e;
endpackage

// File: rtl/wbm_fsm.sv
module wbm_fsm
  import wbm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ready_i,
  output logic accept_o,
  output logic in_odd_o,
  output logic in_even_o,
  output logic odd_fire_o,
  output logic even_fire_o,
  output logic done_o
);
  wbm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i)   state_d = ST_ODD;
      ST_ODD:  if (ready_i) state_d = ST_EVEN;
      ST_EVEN: if (ready_i) state_d = ST_DONE;
      ST_DONE:              state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign accept_o    = (state_q == ST_IDLE) && req_i;
  assign in_odd_o    = (state_q == ST_ODD);
  assign in_even_o   = (state_q == ST_EVEN);
  assign odd_fire_o  = in_odd_o && ready_i;
  assign even_fire_o = in_even_o && ready_i;
  assign done_o      = (state_q == ST_DONE);
endmodule

// File: rtl/wbm_req_reg.sv
module wbm_req_reg #(
  parameter int AW = 15,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o
);
  // held for the whole access; busy-time inputs never reach here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      we_o    <= 1'b0;
      wdata_o <= '0;
    end else if (accept_i) begin
      addr_o  <= addr_i;
      we_o    <= we_i;
      wdata_o <= wdata_i;
    end
  end
endmodule

// File: rtl/wbm_byte_path.sv
module wbm_byte_path #(
  parameter int BW = 8,
  localparam int DW = 2 * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          in_odd_i,
  input  logic          in_even_i,
  input  logic          odd_fire_i,
  input  logic          even_fire_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [BW-1:0] per_rdata_i,
  output logic [BW-1:0] per_wdata_o,
  output logic [DW-1:0] rdata_o
);
  logic [BW-1:0] odd_latch_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_latch_q <= '0;
      rdata_q     <= '0;
    end else begin
      if (odd_fire_i && !we_i)  odd_latch_q <= per_rdata_i;
      if (even_fire_i && !we_i) rdata_q     <= {per_rdata_i, odd_latch_q};
    end
  end

  // odd phase carries the low half, even phase the high half
  for (genvar b = 0; b < BW; b++) begin : g_lane
    assign per_wdata_o[b] = (in_odd_i  & wdata_i[b])
                          | (in_even_i & wdata_i[BW+b]);
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/word_byte_mux.sv
module word_byte_mux #(
  parameter int AW = 15,
  parameter int BW = 8,
  localparam int DW = 2 * BW,
  localparam int PAW = AW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cpu_req_i,
  input  logic           cpu_we_i,
  input  logic [AW-1:0]  cpu_addr_i,
  input  logic [DW-1:0]  cpu_wdata_i,
  output logic [DW-1:0]  cpu_rdata_o,
  output logic           cpu_done_o,
  output logic [PAW-1:0] per_addr_o,
  output logic           per_stb_o,
  output logic           per_we_o,
  output logic [BW-1:0]  per_wdata_o,
  input  logic [BW-1:0]  per_rdata_i,
  input  logic           per_ready_i
);
  logic accept, in_odd, in_even, odd_fire, even_fire;
  logic [AW-1:0] addr_q;
  logic          we_q;
  logic [DW-1:0] wdata_q;

  wbm_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (cpu_req_i),
    .ready_i     (per_ready_i),
    .accept_o    (accept),
    .in_odd_o    (in_odd),
    .in_even_o   (in_even),
    .odd_fire_o  (odd_fire),
    .even_fire_o (even_fire),
    .done_o      (cpu_done_o)
  );

  wbm_req_reg #(.AW(AW), .DW(DW)) u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .addr_i   (cpu_addr_i),
    .we_i     (cpu_we_i),
    .wdata_i  (cpu_wdata_i),
    .addr_o   (addr_q),
    .we_o     (we_q),
    .wdata_o  (wdata_q)
  );

  wbm_byte_path #(.BW(BW)) u_bytes (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we_q),
    .in_odd_i    (in_odd),
    .in_even_i   (in_even),
    .odd_fire_i  (odd_fire),
    .even_fire_i (even_fire),
    .wdata_i     (wdata_q),
    .per_rdata_i (per_rdata_i),
    .per_wdata_o (per_wdata_o),
    .rdata_o     (cpu_rdata_o)
  );

  assign per_stb_o  = in_odd | in_even;
  assign per_we_o   = per_stb_o & we_q;
  assign per_addr_o = {addr_q, in_odd};
endmodule

// File: rtl/wbm_chk.sv
module wbm_chk #(
  parameter int AW = 15,
  parameter int BW = 8,
  localparam int DW = 2 * BW,
  localparam int PAW = AW + 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [DW-1:0]  cpu_rdata_o,
  input logic           cpu_done_o,
  input logic [PAW-1:0] per_addr_o,
  input logic           per_stb_o,
  input logic           per_we_o,
  input logic [BW-1:0]  per_rdata_i,
  input logic           per_ready_i
);
  AST_ODD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_stb_o && per_addr_o[0] && !per_ready_i) |=> (per_stb_o && $stable(per_addr_o))); // R3

  AST_EVEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_stb_o && !per_addr_o[0] && !per_ready_i) |=> (per_stb_o && $stable(per_addr_o))); // R5

  AST_ODD_THEN_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_stb_o && per_addr_o[0] && per_ready_i) |=>
      (per_stb_o && !per_addr_o[0] && per_addr_o[PAW-1:1] == $past(per_addr_o[PAW-1:1]))); // R4

  AST_EVEN_TO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_stb_o && !per_addr_o[0] && per_ready_i) |=> cpu_done_o); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |=> !cpu_done_o); // R7

  AST_NO_STB_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |-> !per_stb_o); // R9

  AST_EVEN_BYTE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_stb_o && !per_addr_o[0] && per_ready_i && !per_we_o) |=>
      (cpu_rdata_o[DW-1:BW] == $past(per_rdata_i))); // R6

  AST_DONE_AFTER_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_done_o && $past(rst_ni)) |-> ($past(per_stb_o) && !$past(per_addr_o[0]))); // R10
endmodule

bind word_byte_mux wbm_chk #(.AW(AW), .BW(BW)) u_wbm_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_rdata_o (cpu_rdata_o),
  .cpu_done_o  (cpu_done_o),
  .per_addr_o  (per_addr_o),
  .per_stb_o   (per_stb_o),
  .per_we_o    (per_we_o),
  .per_rdata_i (per_rdata_i),
  .per_ready_i (per_ready_i)
);

// File: tb/word_byte_mux_bench.sv
module word_byte_mux_bench;
  localparam int AW = 15;
  localparam int BW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cpu_req_i = 1'b0;
  logic          cpu_we_i = 1'b0;
  logic [AW-1:0] cpu_addr_i = '0;
  logic [DW-1:0] cpu_wdata_i = '0;
  logic [DW-1:0] cpu_rdata_o;
  logic          cpu_done_o;
  logic [AW:0]   per_addr_o;
  logic          per_stb_o;
  logic          per_we_o;
  logic [BW-1:0] per_wdata_o;
  logic [BW-1:0] per_rdata_i = '0;
  logic          per_ready_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit summary_done = 0;

  always #4 clk = ~clk;

  word_byte_mux #(.AW(AW), .BW(BW)) u_word_byte_mux (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
    .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o), .cpu_done_o(cpu_done_o),
    .per_addr_o(per_addr_o), .per_stb_o(per_stb_o), .per_we_o(per_we_o),
    .per_wdata_o(per_wdata_o), .per_rdata_i(per_rdata_i), .per_ready_i(per_ready_i)
  );

  function automatic logic [7:0] mem_byte(input logic [AW:0] ba);
    return (ba[7:0] * 8'd29) ^ ba[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [15:0] exp_word(input logic [AW-1:0] wa);
    return {mem_byte({wa, 1'b0}), mem_byte({wa, 1'b1})};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // odd_st/even_st: stall cycles per phase, negative = random
  task automatic run_access(input logic we, input logic [AW-1:0] a, input logic [15:0] wd,
                            input int odd_st, input int even_st, input bit hold);
    int phase = 0;
    int stalls = 0;
    int cyc = 0;
    bit fin = 0;
    bit rdy;
    int target;
    @(negedge clk);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = wd;
    per_ready_i = 1'b0;
    while (!fin && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (hold) begin
        cpu_addr_i = ~a; cpu_wdata_i = ~wd; cpu_we_i = ~we;
      end else begin
        cpu_req_i = 1'b0;
      end
      if (cpu_done_o) begin
        chk(phase == 2, "R10 two byte cycles before done", phase, 2);
        chk(!per_stb_o, "R9 no strobe in done cycle", per_stb_o, 0);
        if (!we) chk(cpu_rdata_o == exp_word(a), "R6 read word", cpu_rdata_o, exp_word(a));
        fin = 1;
        cpu_req_i = 1'b0;
        @(negedge clk);
        chk(!cpu_done_o, "R7 done lasts one clock", cpu_done_o, 0);
        chk(!per_stb_o, "R9 no new access after done", per_stb_o, 0);
        if (!we) chk(cpu_rdata_o == exp_word(a), "R6 read word held", cpu_rdata_o, exp_word(a));
      end else if (per_stb_o && phase < 2) begin
        chk(per_addr_o == {a, phase == 0},
            phase == 0 ? (stalls > 0 ? "R3 odd address held" : "R2 odd address first")
                       : (stalls > 0 ? "R5 even address held" : "R4 even address second"),
            per_addr_o, {a, phase == 0});
        chk(per_we_o == we, "R8 direction per byte", per_we_o, we);
        if (we) chk(per_wdata_o == (phase == 0 ? wd[7:0] : wd[15:8]), "R8 write lane",
                    per_wdata_o, phase == 0 ? wd[7:0] : wd[15:8]);
        target = (phase == 0) ? odd_st : even_st;
        rdy = (target < 0) ? (($urandom % 3) != 0) : (stalls >= target);
        per_ready_i = rdy;
        per_rdata_i = mem_byte(per_addr_o);
        if (rdy) begin phase++; stalls = 0; end
        else stalls++;
      end else begin
        chk(1'b0, phase == 0 ? "R2 strobe after request" : "R4 strobe continuity",
            {per_stb_o, cpu_done_o}, phase);
        fin = 1;
      end
    end
    if (!fin) chk(1'b0, "R7 done never seen", 0, 1);
    per_ready_i = 1'b0;
    cpu_req_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!per_stb_o && !cpu_done_o, "R1 reset quiet", {per_stb_o, cpu_done_o}, 0);
    chk(cpu_rdata_o == 16'h0, "R1 reset rdata", cpu_rdata_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!per_stb_o && !cpu_done_o, "R1 idle after reset", {per_stb_o, cpu_done_o}, 0);

    run_access(1'b0, 15'h1234, 16'h0, 0, 0, 0);
    run_access(1'b0, 15'h0000, 16'h0, 3, 0, 0);
    run_access(1'b0, 15'h7FFF, 16'h0, 0, 4, 0);
    run_access(1'b0, 15'h2AAA, 16'h0, 2, 5, 0);
    run_access(1'b1, 15'h0155, 16'hBEEF, 1, 2, 0);
    run_access(1'b1, 15'h3C3C, 16'hA55A, 0, 0, 0);
    run_access(1'b0, 15'h0ACE, 16'h0, 4, 6, 1); // R9 busy request with changed inputs
    run_access(1'b1, 15'h5151, 16'h1357, 3, 3, 1); // R9

    for (int i = 0; i < 120; i++) begin
      run_access($urandom % 2, $urandom, $urandom, -1, -1, ($urandom % 4) == 0);
    end

    // R1 reset in mid access with a nonzero word already read
    run_access(1'b0, 15'h4321, 16'h0, 0, 0, 0);
    @(negedge clk);
    cpu_req_i = 1'b1; cpu_we_i = 1'b0; cpu_addr_i = 15'h0777;
    per_ready_i = 1'b1;
    @(negedge clk);
    cpu_req_i = 1'b0;
    @(negedge clk);
    per_ready_i = 1'b0;
    chk(per_stb_o && !per_addr_o[0], "R4 even stalled before reset", per_addr_o, {15'h0777, 1'b0});
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(!per_stb_o && !cpu_done_o, "R1 mid-access reset quiet", {per_stb_o, cpu_done_o}, 0);
    chk(cpu_rdata_o == 16'h0, "R1 mid-access reset rdata", cpu_rdata_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!per_stb_o && !cpu_done_o, "R1 idle after second reset", {per_stb_o, cpu_done_o}, 0);
    run_access(1'b0, 15'h0777, 16'h0, 1, 1, 0);

    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!summary_done) begin
      summary_done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  end
endmodule